// File: doc/BRIEF.md
# DRAM Bank Activation Timing Gate

This block sits between a command scheduler and the command pins of a four-bank DRAM. Each cycle the scheduler presents one requested command (activate, read, write, precharge, no-operation or deselect) with a two-bit bank number and an address-bit-10 flag. The flag makes a precharge close every bank instead of one. The gate keeps the open or closed state of each bank and a set of minimum-interval timers. In the same cycle it decides whether the command is legal, and it raises a grant when it is.

A granted command appears on the chip-select, RAS, CAS and WE levels, the bank lines and address bit 10. A refused command produces a no-operation on those pins. The scheduler keeps presenting a refused request until it is granted, so nothing is lost. All timing limits are parameters counted in clock cycles, each at least 1. An N-cycle rule measured from a command granted in cycle k is met from cycle k+N onward.

Top module: `dram_bank_gate`

## Requirements
- R1: Granted commands drive {cs_n, ras_n, cas_n, we_n} as follows: activate 0011, read 0101, write 0100, precharge 0010, no-operation 0111, deselect 1111. The req_cmd codes are 0 no-operation, 1 activate, 2 read, 3 write, 4 precharge and 5 deselect.
- R2: No-operation and deselect are always granted. Codes 6 and 7 are always refused. A refused request drives grant 0, pins 0111, bank lines 0 and a10 0.
- R3: A read or write to a bank is granted only if that bank is open and at least TRCD cycles have passed since its activate.
- R4: An activate to a bank that is already open is refused.
- R5: An activate is refused if it is fewer than TRRD cycles after the last activate to a different bank, or fewer than TRC cycles after the last activate to the same bank.
- R6: An activate to a bank is refused until TRP cycles after that bank was precharged.
- R7: A precharge with req_ap 0 closes only the addressed bank. It is refused until TWR cycles after the last write to that bank.
- R8: A precharge with req_ap 1 ignores req_bank and closes every bank. It is granted only when every bank's TWR interval has elapsed.
- R9: A granted activate, read, write or single-bank precharge puts req_bank on ba. A granted all-bank precharge drives ba 0 and a10 1. a10 is 0 for every other command.
- R10: A synchronous active-low reset closes every bank and clears all timers, so any activate is legal in the first cycle after reset.
- R11: A request held unchanged while refused is granted in the first cycle it becomes legal. A read held after an activate is refused for exactly TRCD-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd | input | 3 | Requested command code (see R1) |
| req_bank | input | 2 | Requested bank number |
| req_ap | input | 1 | Address bit 10 request; on a precharge it selects all banks |
| grant | output | 1 | The requested command is issued this cycle |
| cs_n | output | 1 | Chip-select level |
| ras_n | output | 1 | RAS level |
| cas_n | output | 1 | CAS level |
| we_n | output | 1 | WE level |
| ba | output | 2 | Bank lines |
| a10 | output | 1 | Address bit 10 level |

## Verification
Grant, the four control levels, ba and a10 all follow the request in the same cycle. They are combinational from the request and the registered bank state. A granted command changes that state at the rising edge that ends its cycle, so a rule of N cycles first allows the next command N cycles after the grant. The bench changes inputs on the falling edge and compares outputs one nanosecond later, before the next rising edge. Each expected grant is therefore counted in whole cycles from the cycle in which the earlier command was granted.

// File: rtl/dbg_pkg.sv
// Shared definitions for the DRAM bank timing gate.
// Assumes a four-bank device with a two-bit bank number.
package dbg_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;

    // Request command codes seen on req_cmd
    localparam logic [2:0] CMD_NOP  = 3'd0;
    localparam logic [2:0] CMD_ACT  = 3'd1;
    localparam logic [2:0] CMD_RD   = 3'd2;
    localparam logic [2:0] CMD_WR   = 3'd3;
    localparam logic [2:0] CMD_PRE  = 3'd4;
    localparam logic [2:0] CMD_DSEL = 3'd5;

    // Active-low command pin levels
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ctl_pins_t;

    localparam ctl_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ctl_pins_t PINS_ACT  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam ctl_pins_t PINS_RD   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam ctl_pins_t PINS_WR   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
    localparam ctl_pins_t PINS_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam ctl_pins_t PINS_DSEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/gap_timer.sv
// Minimum-interval timer. A load starts a span of SPAN cycles.
// done is high again from the SPAN-th cycle after the load cycle.
// Assumes SPAN >= 1; with SPAN == 1 done never drops.
module gap_timer #(
    parameter int SPAN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [W-1:0] RELOAD = W'(SPAN - 1);

    logic [W-1:0] cnt_q;

    // Count down to zero after each load
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/bank_tracker.sv
// State of one bank: open flag plus four interval timers.
// It reports which command classes the bank would accept now.
// Assumes at most one go strobe is high per cycle.
module bank_tracker #(
    parameter int TRCD = 3,
    parameter int TRC  = 8,
    parameter int TRP  = 3,
    parameter int TWR  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic wr_go,
    input  logic pre_go,
    output logic is_open,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok
);
    logic open_q;
    logic rcd_done, rc_done, rp_done, wr_done;

    gap_timer #(.SPAN(TRCD)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_go), .done(rcd_done));
    gap_timer #(.SPAN(TRC))  u_rc  (.clk(clk), .rst_n(rst_n), .load(act_go), .done(rc_done));
    gap_timer #(.SPAN(TRP))  u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_go), .done(rp_done));
    gap_timer #(.SPAN(TWR))  u_wr  (.clk(clk), .rst_n(rst_n), .load(wr_go),  .done(wr_done));

    // Open on activate, close on precharge
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (act_go)
            open_q <= 1'b1;
        else if (pre_go)
            open_q <= 1'b0;
    end

    assign is_open = open_q;
    assign act_ok  = !open_q && rc_done && rp_done;
    assign col_ok  = open_q && rcd_done;
    assign pre_ok  = wr_done;
endmodule

// File: rtl/cmd_encoder.sv
// Turns a granted request into command pin levels, bank lines and a10.
// Anything not granted becomes a no-operation with zeroed address lines.
module cmd_encoder
    import dbg_pkg::*;
(
    input  logic              grant,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic              ap,
    output ctl_pins_t         pins,
    output logic [BANK_W-1:0] ba,
    output logic              a10
);
    // Select pin levels and address lines for the issued command
    always_comb begin
        pins = PINS_NOP;
        ba   = '0;
        a10  = 1'b0;
        if (grant) begin
            case (cmd)
                CMD_ACT:  begin pins = PINS_ACT; ba = bank; end
                CMD_RD:   begin pins = PINS_RD;  ba = bank; end
                CMD_WR:   begin pins = PINS_WR;  ba = bank; end
                CMD_PRE:  begin
                    pins = PINS_PRE;
                    a10  = ap;
                    ba   = ap ? '0 : bank;
                end
                CMD_DSEL: pins = PINS_DSEL;
                default:  pins = PINS_NOP;
            endcase
        end
    end
endmodule

// File: rtl/dram_bank_gate.sv
// Top of the bank timing gate. It decides each cycle whether the requested
// command is legal, grants it and drives the command pins.
// Assumes the requester holds a refused request until it is granted.
module dram_bank_gate
    import dbg_pkg::*;
#(
    parameter int TRCD = 3,
    parameter int TRRD = 2,
    parameter int TRC  = 8,
    parameter int TRP  = 3,
    parameter int TWR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_ap,
    output logic              grant,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic              a10
);
    logic [NUM_BANKS-1:0] bank_open, act_ok, col_ok, pre_ok;
    logic [NUM_BANKS-1:0] act_go, wr_go, pre_go;
    logic                 rrd_done, rrd_ok, legal;
    logic [BANK_W-1:0]    last_act_bank_q;
    ctl_pins_t            pins;

    wire is_act = (req_cmd == CMD_ACT);
    wire is_wr  = (req_cmd == CMD_WR);
    wire is_pre = (req_cmd == CMD_PRE);

    // One tracker per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        wire hit = (req_bank == BANK_W'(b));
        assign act_go[b] = grant && is_act && hit;
        assign wr_go[b]  = grant && is_wr && hit;
        assign pre_go[b] = grant && is_pre && (req_ap || hit);

        bank_tracker #(.TRCD(TRCD), .TRC(TRC), .TRP(TRP), .TWR(TWR)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_go (act_go[b]),
            .wr_go  (wr_go[b]),
            .pre_go (pre_go[b]),
            .is_open(bank_open[b]),
            .act_ok (act_ok[b]),
            .col_ok (col_ok[b]),
            .pre_ok (pre_ok[b])
        );
    end

    // Shared spacing between activates to different banks
    gap_timer #(.SPAN(TRRD)) u_rrd (
        .clk  (clk),
        .rst_n(rst_n),
        .load (grant && is_act),
        .done (rrd_done)
    );

    // Remember which bank took the last activate
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_act_bank_q <= '0;
        else if (grant && is_act)
            last_act_bank_q <= req_bank;
    end

    assign rrd_ok = rrd_done || (req_bank == last_act_bank_q);

    // Legality of the current request
    always_comb begin
        case (req_cmd)
            CMD_NOP, CMD_DSEL: legal = 1'b1;
            CMD_ACT:           legal = act_ok[req_bank] && rrd_ok;
            CMD_RD, CMD_WR:    legal = col_ok[req_bank];
            CMD_PRE:           legal = req_ap ? (&pre_ok) : pre_ok[req_bank];
            default:           legal = 1'b0;
        endcase
    end

    assign grant = legal;

    cmd_encoder u_enc (
        .grant(grant),
        .cmd  (req_cmd),
        .bank (req_bank),
        .ap   (req_ap),
        .pins (pins),
        .ba   (ba),
        .a10  (a10)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
endmodule

// File: rtl/dram_bank_gate_chk.sv
// Timing and encoding properties of the bank gate, seen from its ports.
module dram_bank_gate_chk #(
    parameter int TRCD = 3,
    parameter int TRC  = 8,
    parameter int TRP  = 3,
    parameter int TWR  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] req_cmd,
    input logic [1:0] req_bank,
    input logic       req_ap,
    input logic       grant,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] ba,
    input logic       a10
);
    // R2
    refused_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && ba == 2'd0 && !a10));

    // R2
    nop_always_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == 3'd0 || req_cmd == 3'd5) |-> grant);

    // R1
    deselect_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == 3'd5) |-> (cs_n && ras_n && cas_n && we_n));

    // R4
    no_double_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd1) |=>
        !(grant && req_cmd == 3'd1 && req_bank == $past(req_bank)));

    // R3
    rcd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (TRCD > 1 && grant && req_cmd == 3'd1) |=>
        !(grant && (req_cmd == 3'd2 || req_cmd == 3'd3) && req_bank == $past(req_bank)));

    // R7
    write_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (TWR > 1 && grant && req_cmd == 3'd3) |=>
        !(grant && req_cmd == 3'd4 && (req_ap || req_bank == $past(req_bank))));

    // R6
    precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (TRP > 1 && grant && req_cmd == 3'd4) |=>
        !(grant && req_cmd == 3'd1 && ($past(req_ap) || req_bank == $past(req_bank))));

    // R9
    all_bank_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd4 && req_ap) |-> (a10 && ba == 2'd0));
endmodule

bind dram_bank_gate dram_bank_gate_chk #(
    .TRCD(TRCD), .TRC(TRC), .TRP(TRP), .TWR(TWR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_ap(req_ap), .grant(grant), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10)
);

// File: tb/tb_dram_bank_gate.sv
// Self-checking bench: a vector table walked cycle by cycle, then directed
// checks for reset, retry and precharge scope. Defaults: TRCD 3, TRRD 2,
// TRC 8, TRP 3, TWR 3.
module tb_dram_bank_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic       req_ap = 1'b0;
    logic       grant, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dram_bank_gate dut (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_ap(req_ap), .grant(grant), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10)
    );

    // Expected {grant, cs_n, ras_n, cas_n, we_n, ba, a10} from R1, R2, R9
    function automatic logic [7:0] expect_out(input logic g, input logic [2:0] c,
                                              input logic [1:0] b, input logic ap);
        logic [3:0] p;
        logic [1:0] eb;
        logic       ea;
        p = 4'b0111; eb = 2'd0; ea = 1'b0;
        if (g) begin
            case (c)
                3'd1: begin p = 4'b0011; eb = b; end
                3'd2: begin p = 4'b0101; eb = b; end
                3'd3: begin p = 4'b0100; eb = b; end
                3'd4: begin p = 4'b0010; ea = ap; eb = ap ? 2'd0 : b; end
                3'd5: p = 4'b1111;
                default: p = 4'b0111;
            endcase
        end
        return {g, p, eb, ea};
    endfunction

    // Drive one request on the falling edge, compare before the rising edge
    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic ap,
                        input logic g, input int rq);
        logic [7:0] got, exp;
        @(negedge clk);
        req_cmd = c; req_bank = b; req_ap = ap;
        #1;
        got = {grant, cs_n, ras_n, cas_n, we_n, ba, a10};
        exp = expect_out(g, c, b, ap);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d cmd=%0d bank=%0d: got %b expected %b", rq, c, b, got, exp);
        end
    endtask

    // {cmd, bank, ap, expected grant, requirement number}
    localparam int NV = 25;
    localparam logic [10:0] VEC [NV] = '{
        {3'd2, 2'd0, 1'b0, 1'b0, 4'd3},  // 0  R3 read to closed bank
        {3'd1, 2'd0, 1'b0, 1'b1, 4'd1},  // 1  activate b0
        {3'd1, 2'd1, 1'b0, 1'b0, 4'd5},  // 2  R5 TRRD
        {3'd1, 2'd1, 1'b0, 1'b1, 4'd5},  // 3  activate b1
        {3'd2, 2'd0, 1'b0, 1'b1, 4'd3},  // 4  R3 TRCD met
        {3'd3, 2'd1, 1'b0, 1'b0, 4'd3},  // 5  TRCD not met
        {3'd3, 2'd1, 1'b0, 1'b1, 4'd3},  // 6  write b1
        {3'd4, 2'd1, 1'b0, 1'b0, 4'd7},  // 7  R7 TWR
        {3'd4, 2'd2, 1'b1, 1'b0, 4'd8},  // 8  R8 all waits for b1 TWR
        {3'd1, 2'd0, 1'b0, 1'b0, 4'd4},  // 9  R4 already open
        {3'd4, 2'd0, 1'b1, 1'b1, 4'd8},  // 10 precharge all
        {3'd1, 2'd2, 1'b0, 1'b0, 4'd6},  // 11 R6 TRP
        {3'd0, 2'd0, 1'b0, 1'b1, 4'd2},  // 12 nop
        {3'd1, 2'd2, 1'b0, 1'b1, 4'd6},  // 13 TRP met
        {3'd1, 2'd0, 1'b0, 1'b0, 4'd5},  // 14 TRRD
        {3'd1, 2'd0, 1'b0, 1'b1, 4'd5},  // 15 activate b0
        {3'd4, 2'd2, 1'b0, 1'b1, 4'd9},  // 16 R9 single precharge b2
        {3'd1, 2'd2, 1'b0, 1'b0, 4'd6},  // 17 TRP
        {3'd2, 2'd2, 1'b0, 1'b0, 4'd3},  // 18 closed
        {3'd1, 2'd2, 1'b0, 1'b0, 4'd5},  // 19 TRC same bank
        {3'd1, 2'd2, 1'b0, 1'b0, 4'd5},  // 20 TRC same bank
        {3'd1, 2'd2, 1'b0, 1'b1, 4'd5},  // 21 TRC met
        {3'd5, 2'd3, 1'b1, 1'b1, 4'd1},  // 22 R1 deselect
        {3'd7, 2'd0, 1'b0, 1'b0, 4'd2},  // 23 R2 reserved code
        {3'd2, 2'd0, 1'b0, 1'b1, 4'd3}   // 24 read b0
    };

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int refused;
        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(3'd0, 2'd0, 1'b0, 1'b1, 10);

        for (int i = 0; i < NV; i++)
            step(VEC[i][10:8], VEC[i][7:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));

        // R11 hold a refused read until granted
        step(3'd1, 2'd3, 1'b0, 1'b1, 11);
        refused = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            req_cmd = 3'd2; req_bank = 2'd3; req_ap = 1'b0;
            #1;
            if (grant) break;
            refused++;
        end
        n_chk++;
        if (refused != 2) begin
            n_bad++;
            $display("FAIL R11 held read: got %0d refused expected 2", refused);
        end

        // R10 reset mid-run closes banks and clears timers
        @(negedge clk);
        rst_n = 1'b0; req_cmd = 3'd0;
        @(negedge clk);
        rst_n = 1'b1;
        step(3'd2, 2'd3, 1'b0, 1'b0, 10);
        step(3'd1, 2'd0, 1'b0, 1'b1, 10);

        // R7 single precharge leaves other banks open; R8 all-bank waits TWR
        step(3'd0, 2'd0, 1'b0, 1'b1, 2);
        step(3'd1, 2'd1, 1'b0, 1'b1, 5);
        step(3'd0, 2'd0, 1'b0, 1'b1, 2);
        step(3'd0, 2'd0, 1'b0, 1'b1, 2);
        step(3'd4, 2'd1, 1'b0, 1'b1, 7);
        step(3'd2, 2'd0, 1'b0, 1'b1, 7);
        step(3'd2, 2'd1, 1'b0, 1'b0, 7);
        step(3'd3, 2'd0, 1'b0, 1'b1, 3);
        step(3'd4, 2'd3, 1'b1, 1'b0, 8);
        step(3'd0, 2'd0, 1'b0, 1'b1, 2);
        step(3'd4, 2'd3, 1'b1, 1'b1, 8);
        step(3'd2, 2'd0, 1'b0, 1'b0, 8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule